// File: doc/BRIEF.md
# Harris Corner Response Pipeline

This block turns a square greyscale frame, streamed one pixel per cycle in raster order, into a stream of signed corner-strength values, one for each input pixel and in the same order. The pixel passes through four fixed stages. A 3x3 Sobel pair gives a horizontal and a vertical gradient. The block then forms the three gradient products. A 3x3 binomial blur smooths each product plane on its own. A final stage forms the determinant of the smoothed structure tensor.

The frame edge length `W` is a parameter. The supported sizes are 8, 16, 32 and 64, with a height equal to the width. Each windowed stage holds two lines plus three samples in a register shift chain. That chain advances on every clock, so the pixels of one frame must arrive on consecutive cycles, starting with the pixel flagged as start of frame. Idle cycles may come between frames, and a new frame may also follow the previous one directly. Results leave the block after a fixed delay. No thresholding or peak picking is done here.

Top module: `harris_corner`

## Requirements
- R1: The horizontal gradient Ix is the right column minus the left column of the 3x3 neighbourhood, weighted 1,2,1 from top to bottom. The vertical gradient Iy is the bottom row minus the top row, weighted 1,2,1 from left to right. Both are 11-bit signed values.
- R2: The products Ixx=Ix*Ix, Iyy=Iy*Iy and Ixy=Ix*Iy are each blurred on their own with weights 4 at the centre, 2 at the edge neighbours and 1 at the corners. Each weighted sum is shifted right arithmetically by 4, which rounds toward negative infinity.
- R3: out_k equals Sxx*Syy minus Sxy*Sxy as a 45-bit two's-complement number, exact for every 8-bit input, including alternating 0/255 patterns.
- R4: At the frame border, any neighbour that falls outside the frame takes the value of the nearest in-frame sample, with row and column clamped separately. This applies at the gradient stage and at the blur stage.
- R5: Each pixel accepted with in_valid high produces exactly one output with out_valid high, in raster order, right after the 2W+7th rising edge that follows the edge that accepted the pixel.
- R6: out_sof is high together with out_valid on the output of each frame's first pixel, and is low at all other times.
- R7: A frame in which every pixel has the same value gives out_k = 0 for every pixel.
- R8: In reset, out_valid, out_sof and out_k are all 0. While out_valid is low, out_k holds its last value.
- R9: A frame that starts on the cycle right after the last pixel of the previous frame is processed as if it stood alone. No sample of one frame reaches the result of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Pixel present on in_pix |
| in_sof | input | 1 | Marks the first pixel of a frame (used only with in_valid) |
| in_pix | input | 8 | Unsigned greyscale pixel |
| out_valid | output | 1 | Corner value present on out_k |
| out_sof | output | 1 | Marks the first result of a frame |
| out_k | output | 45 | Signed corner strength Sxx*Syy - Sxy*Sxy |

## Verification
The bench drives each pixel at a falling edge, so it is accepted at the next rising edge. Its result must then be visible 2W+8 falling edges after it was driven: 2W+7 register edges for the gradient chain, the gradient and product registers, the blur chain, the blur register and the response register, plus one edge for sampling. At every falling edge of a run, the bench compares out_valid, out_sof and out_k against a reference model evaluated at that fixed offset. Before the first result and after the last one, it requires out_valid low and out_k unchanged. The checker tracks the same 2W+7-edge distance with a delay line of input flags, rather than a deep past reference.

// File: rtl/harris_pkg.sv
package harris_pkg;

    localparam int PIX_W    = 8;
    localparam int GRAD_W   = PIX_W + 3;            // |Sobel| <= 4*(2^PIX_W-1)
    localparam int PROD_W   = 2 * GRAD_W;           // square of a gradient
    localparam int GSHIFT   = 4;                    // blur weights sum to 16
    localparam int ACC_W    = PROD_W + GSHIFT + 1;  // blur sum before the shift
    localparam int RESP_W   = 2 * PROD_W + 1;       // difference of two products

    typedef logic signed [GRAD_W-1:0] grad_t;
    typedef logic signed [PROD_W-1:0] prod_t;
    typedef logic signed [ACC_W-1:0]  acc_t;
    typedef logic signed [RESP_W-1:0] resp_t;

    typedef struct packed {
        grad_t gx;
        grad_t gy;
    } grad_pair_t;

    typedef struct packed {
        prod_t xx;
        prod_t yy;
        prod_t xy;
    } tensor_t;

    localparam int TENSOR_W = $bits(tensor_t);

    function automatic int pipe_latency(int w);
        return 2 * w + 7;
    endfunction

    function automatic grad_t pix_to_grad(logic [PIX_W-1:0] p);
        return grad_t'({{(GRAD_W-PIX_W){1'b0}}, p});
    endfunction

    function automatic prod_t grad_to_prod(grad_t g);
        return prod_t'({{(PROD_W-GRAD_W){g[GRAD_W-1]}}, g});
    endfunction

    function automatic acc_t prod_to_acc(prod_t v);
        return acc_t'({{(ACC_W-PROD_W){v[PROD_W-1]}}, v});
    endfunction

    function automatic resp_t prod_to_resp(prod_t v);
        return resp_t'({{(RESP_W-PROD_W){v[PROD_W-1]}}, v});
    endfunction

    // plane index: 0 -> xx, 1 -> yy, 2 -> xy
    function automatic prod_t plane_of(tensor_t t, int p);
        case (p)
            0:       return t.xx;
            1:       return t.yy;
            default: return t.xy;
        endcase
    endfunction

    // log2 of the binomial weight at window slot k (row-major)
    function automatic int blur_shift(int k);
        return (((k / 3) == 1) ? 1 : 0) + (((k % 3) == 1) ? 1 : 0);
    endfunction

endpackage

// File: rtl/harris_win3.sv
module harris_win3 #(
    parameter int W  = 8,
    parameter int DW = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic               in_sof,
    input  logic [DW-1:0]      in_data,
    output logic [8:0][DW-1:0] win,
    output logic               win_valid,
    output logic               win_sof
);
    localparam int DEPTH  = 2 * W + 3;
    localparam int CENTER = W + 1;
    localparam int CW     = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    typedef struct packed {
        logic          v;
        logic          s;
        logic [DW-1:0] d;
    } tap_t;

    tap_t chain [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) chain[i] <= '0;
        end else begin
            chain[0] <= '{v: in_valid, s: in_valid & in_sof, d: in_data};
            for (int i = 1; i < DEPTH; i++) chain[i] <= chain[i-1];
        end
    end

    // position of the sample sitting at the window centre
    logic [CW-1:0] nxt_col, nxt_row, cur_col, cur_row;

    assign cur_col = chain[CENTER].s ? '0 : nxt_col;
    assign cur_row = chain[CENTER].s ? '0 : nxt_row;

    always_ff @(posedge clk) begin
        if (rst) begin
            nxt_col <= '0;
            nxt_row <= '0;
        end else if (chain[CENTER].v) begin
            if (cur_col == LAST) begin
                nxt_col <= '0;
                nxt_row <= (cur_row == LAST) ? '0 : cur_row + 1'b1;
            end else begin
                nxt_col <= cur_col + 1'b1;
                nxt_row <= cur_row;
            end
        end
    end

    // raw 3x3 taps, row-major, top-left first
    logic [8:0][DW-1:0] raw;

    for (genvar r = 0; r < 3; r++) begin : g_row
        for (genvar c = 0; c < 3; c++) begin : g_col
            assign raw[r*3+c] = chain[(2-r)*W + (2-c)].d;
        end
    end

    logic at_top, at_bot, at_lft, at_rgt;
    assign at_top = (cur_row == '0);
    assign at_bot = (cur_row == LAST);
    assign at_lft = (cur_col == '0);
    assign at_rgt = (cur_col == LAST);

    function automatic int clamp_slot(int i, logic lo, logic hi);
        if (i == 0 && lo) return 1;
        if (i == 2 && hi) return 1;
        return i;
    endfunction

    always_comb begin
        for (int r = 0; r < 3; r++) begin
            for (int c = 0; c < 3; c++) begin
                win[r*3+c] = raw[clamp_slot(r, at_top, at_bot)*3 + clamp_slot(c, at_lft, at_rgt)];
            end
        end
    end

    assign win_valid = chain[CENTER].v;
    assign win_sof   = chain[CENTER].s;

endmodule

// File: rtl/harris_grad.sv
module harris_grad
    import harris_pkg::*;
#(
    parameter int W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic [PIX_W-1:0] in_pix,
    output logic             out_valid,
    output logic             out_sof,
    output tensor_t          out_t
);
    logic [8:0][PIX_W-1:0] win;
    logic                  win_valid, win_sof;

    harris_win3 #(.W(W), .DW(PIX_W)) u_win (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_sof    (in_sof),
        .in_data   (in_pix),
        .win       (win),
        .win_valid (win_valid),
        .win_sof   (win_sof)
    );

    grad_t      p [9];
    grad_pair_t g_c;

    always_comb begin
        for (int k = 0; k < 9; k++) p[k] = pix_to_grad(win[k]);
        g_c.gx = (p[2] + (p[5] <<< 1) + p[8]) - (p[0] + (p[3] <<< 1) + p[6]);
        g_c.gy = (p[6] + (p[7] <<< 1) + p[8]) - (p[0] + (p[1] <<< 1) + p[2]);
    end

    grad_pair_t g_q;
    logic       g_valid, g_sof;

    always_ff @(posedge clk) begin
        if (rst) begin
            g_valid   <= 1'b0;
            g_sof     <= 1'b0;
            g_q       <= '0;
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
            out_t     <= '0;
        end else begin
            g_valid   <= win_valid;
            g_sof     <= win_sof;
            g_q       <= g_c;
            out_valid <= g_valid;
            out_sof   <= g_sof;
            out_t.xx  <= grad_to_prod(g_q.gx) * grad_to_prod(g_q.gx);
            out_t.yy  <= grad_to_prod(g_q.gy) * grad_to_prod(g_q.gy);
            out_t.xy  <= grad_to_prod(g_q.gx) * grad_to_prod(g_q.gy);
        end
    end

endmodule

// File: rtl/harris_smooth.sv
module harris_smooth
    import harris_pkg::*;
#(
    parameter int W = 8
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    in_valid,
    input  logic    in_sof,
    input  tensor_t in_t,
    output logic    out_valid,
    output logic    out_sof,
    output tensor_t out_t
);
    logic [8:0][TENSOR_W-1:0] win;
    logic                     win_valid, win_sof;

    harris_win3 #(.W(W), .DW(TENSOR_W)) u_win (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_sof    (in_sof),
        .in_data   (in_t),
        .win       (win),
        .win_valid (win_valid),
        .win_sof   (win_sof)
    );

    tensor_t tw [9];
    always_comb begin
        for (int k = 0; k < 9; k++) tw[k] = tensor_t'(win[k]);
    end

    prod_t sm [3];

    for (genvar pl = 0; pl < 3; pl++) begin : g_plane
        acc_t acc;
        always_comb begin
            acc = '0;
            for (int k = 0; k < 9; k++) begin
                acc = acc + (prod_to_acc(plane_of(tw[k], pl)) <<< blur_shift(k));
            end
        end
        assign sm[pl] = acc[GSHIFT +: PROD_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
            out_t     <= '0;
        end else begin
            out_valid <= win_valid;
            out_sof   <= win_sof;
            out_t     <= '{xx: sm[0], yy: sm[1], xy: sm[2]};
        end
    end

endmodule

// File: rtl/harris_resp.sv
module harris_resp
    import harris_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    in_valid,
    input  logic    in_sof,
    input  tensor_t in_t,
    output logic    out_valid,
    output logic    out_sof,
    output resp_t   out_k
);
    resp_t a, b, c, k_c;

    always_comb begin
        a   = prod_to_resp(in_t.xx);
        b   = prod_to_resp(in_t.yy);
        c   = prod_to_resp(in_t.xy);
        k_c = (a * b) - (c * c);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
            out_k     <= '0;
        end else begin
            out_valid <= in_valid;
            out_sof   <= in_sof;
            if (in_valid) out_k <= k_c;
        end
    end

endmodule

// File: rtl/harris_corner.sv
module harris_corner
    import harris_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic                     in_sof,
    input  logic [PIX_W-1:0]         in_pix,
    output logic                     out_valid,
    output logic                     out_sof,
    output logic signed [RESP_W-1:0] out_k
);
    logic    gr_valid, gr_sof;
    tensor_t gr_t;
    logic    sm_valid, sm_sof;
    tensor_t sm_t;
    resp_t   k_q;

    harris_grad #(.W(W)) u_grad (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_sof    (in_sof),
        .in_pix    (in_pix),
        .out_valid (gr_valid),
        .out_sof   (gr_sof),
        .out_t     (gr_t)
    );

    harris_smooth #(.W(W)) u_smooth (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (gr_valid),
        .in_sof    (gr_sof),
        .in_t      (gr_t),
        .out_valid (sm_valid),
        .out_sof   (sm_sof),
        .out_t     (sm_t)
    );

    harris_resp u_resp (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (sm_valid),
        .in_sof    (sm_sof),
        .in_t      (sm_t),
        .out_valid (out_valid),
        .out_sof   (out_sof),
        .out_k     (k_q)
    );

    assign out_k = k_q;

endmodule

// File: rtl/harris_corner_chk.sv
module harris_corner_chk
    import harris_pkg::*;
#(
    parameter int W = 8
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     in_valid,
    input logic                     in_sof,
    input logic [PIX_W-1:0]         in_pix,
    input logic                     out_valid,
    input logic                     out_sof,
    input logic signed [RESP_W-1:0] out_k
);
    localparam int LAT = pipe_latency(W);

    logic [LAT:0] vd, sd;

    always_ff @(posedge clk) begin
        if (rst) begin
            vd <= '0;
            sd <= '0;
        end else begin
            vd <= {vd[LAT-1:0], in_valid};
            sd <= {sd[LAT-1:0], in_valid & in_sof};
        end
    end

    logic [PIX_W-1:0] pix_seen;
    assign pix_seen = in_pix;

    assert_latency_R5: assert property (@(posedge clk) disable iff (rst)
        out_valid == vd[LAT]);

    assert_sof_align_R6: assert property (@(posedge clk) disable iff (rst)
        out_sof == sd[LAT]);

    assert_sof_has_valid_R6: assert property (@(posedge clk) disable iff (rst)
        out_sof |-> out_valid);

    assert_hold_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_k));

endmodule

bind harris_corner harris_corner_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_sof    (in_sof),
    .in_pix    (in_pix),
    .out_valid (out_valid),
    .out_sof   (out_sof),
    .out_k     (out_k)
);

// File: tb/tb_harris_corner.sv
module tb_harris_corner;
    import harris_pkg::*;

    localparam int W          = 8;
    localparam int N          = W * W;
    localparam int LAT        = 2 * W + 7;
    localparam int OBS        = LAT + 1;   // falling edges from drive to visible result
    localparam int CLK_PERIOD = 10;

    logic                     clk = 1'b0;
    logic                     rst;
    logic                     in_valid, in_sof;
    logic [7:0]               in_pix;
    logic                     out_valid, out_sof;
    logic signed [RESP_W-1:0] out_k;

    always #(CLK_PERIOD/2) clk = ~clk;

    harris_corner #(.W(W)) dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_sof    (in_sof),
        .in_pix    (in_pix),
        .out_valid (out_valid),
        .out_sof   (out_sof),
        .out_k     (out_k)
    );

    int     checks = 0;
    int     fails  = 0;
    bit     done   = 1'b0;
    int     frame_pix [2][N];
    longint exp_k [2*N];
    longint last_k = 0;

    task automatic check_eq(string req, string what, longint act, longint expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    function automatic int clampi(int v);
        return (v < 0) ? 0 : ((v > W - 1) ? W - 1 : v);
    endfunction

    // reference model: clamped Sobel, products, clamped 1-2-1 blur >>> 4, determinant
    task automatic model(int f);
        longint gx [N];
        longint gy [N];
        longint pl [3][N];
        for (int r = 0; r < W; r++) begin
            for (int c = 0; c < W; c++) begin
                longint sx = 0, sy = 0;
                for (int dr = -1; dr <= 1; dr++) begin
                    for (int dc = -1; dc <= 1; dc++) begin
                        longint p = frame_pix[f][clampi(r+dr)*W + clampi(c+dc)];
                        sx += dc * ((dr == 0) ? 2 : 1) * p;
                        sy += dr * ((dc == 0) ? 2 : 1) * p;
                    end
                end
                gx[r*W+c] = sx;
                gy[r*W+c] = sy;
                pl[0][r*W+c] = sx * sx;
                pl[1][r*W+c] = sy * sy;
                pl[2][r*W+c] = sx * sy;
            end
        end
        for (int r = 0; r < W; r++) begin
            for (int c = 0; c < W; c++) begin
                longint s [3];
                for (int q = 0; q < 3; q++) begin
                    longint acc = 0;
                    for (int dr = -1; dr <= 1; dr++) begin
                        for (int dc = -1; dc <= 1; dc++) begin
                            acc += ((dr == 0) ? 2 : 1) * ((dc == 0) ? 2 : 1)
                                   * pl[q][clampi(r+dr)*W + clampi(c+dc)];
                        end
                    end
                    s[q] = acc >>> 4;
                end
                exp_k[f*N + r*W + c] = s[0] * s[1] - s[2] * s[2];
            end
        end
    endtask

    // drives nf contiguous frames and checks every falling edge at the fixed offset
    task automatic run_stream(int nf, string ktag);
        int total = nf * N;
        for (int n = 0; n < total + OBS + 3; n++) begin
            int idx;
            @(negedge clk);
            idx = n - OBS;
            if (idx >= 0 && idx < total) begin
                check_eq("R5", "out_valid", longint'(out_valid), 1);
                check_eq("R6", "out_sof", longint'(out_sof), longint'(idx % N == 0));
                check_eq(ktag, "out_k", longint'(out_k), exp_k[idx]);
                last_k = exp_k[idx];
            end else begin
                check_eq("R5", "idle out_valid", longint'(out_valid), 0);
                check_eq("R6", "idle out_sof", longint'(out_sof), 0);
                check_eq("R8", "idle out_k hold", longint'(out_k), last_k);
            end
            if (n < total) begin
                in_valid = 1'b1;
                in_sof   = (n % N == 0);
                in_pix   = 8'(frame_pix[n / N][n % N]);
            end else begin
                in_valid = 1'b0;
                in_sof   = 1'b0;
                in_pix   = 8'd0;
            end
        end
    endtask

    task automatic test_reset();
        @(negedge clk);
        check_eq("R8", "reset out_valid", longint'(out_valid), 0);
        check_eq("R8", "reset out_sof", longint'(out_sof), 0);
        check_eq("R8", "reset out_k", longint'(out_k), 0);
    endtask

    task automatic test_constant();
        for (int i = 0; i < N; i++) frame_pix[0][i] = 200;
        model(0);
        for (int i = 0; i < N; i++) check_eq("R7", "model zero", exp_k[i], 0);
        run_stream(1, "R7");
    endtask

    task automatic test_random();
        for (int i = 0; i < N; i++) frame_pix[0][i] = int'($urandom_range(0, 255));
        model(0);
        run_stream(1, "R1 R2 R3");
    endtask

    task automatic test_hramp();
        for (int i = 0; i < N; i++) frame_pix[0][i] = (i % W) * 30;
        model(0);
        run_stream(1, "R1");
    endtask

    task automatic test_vramp();
        for (int i = 0; i < N; i++) frame_pix[0][i] = 255 - (i / W) * 29;
        model(0);
        run_stream(1, "R1");
    endtask

    task automatic test_corner_dot();
        for (int i = 0; i < N; i++) frame_pix[0][i] = 0;
        frame_pix[0][0]   = 255;
        frame_pix[0][N-1] = 180;
        model(0);
        run_stream(1, "R4");
    endtask

    task automatic test_checker();
        for (int i = 0; i < N; i++) frame_pix[0][i] = (((i / W) + (i % W)) % 2 == 0) ? 255 : 0;
        model(0);
        run_stream(1, "R3");
    endtask

    task automatic test_back_to_back();
        for (int i = 0; i < N; i++) frame_pix[0][i] = int'($urandom_range(0, 255));
        for (int i = 0; i < N; i++) frame_pix[1][i] = 17;
        model(0);
        model(1);
        run_stream(2, "R9");
    endtask

    initial begin
        rst      = 1'b1;
        in_valid = 1'b0;
        in_sof   = 1'b0;
        in_pix   = 8'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        test_reset();
        test_constant();
        test_random();
        test_hramp();
        test_vramp();
        test_corner_dot();
        test_checker();
        test_back_to_back();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule